// File: doc/BRIEF.md
# Flash Byte Programming Sequencer

This block sequences programming of a small on-chip code flash. The flash is modelled as a register array of 2^ADDR_W bytes. A host presents an address, a data byte and an operation code, then strobes an active-low program pulse. The sequencer decodes that pulse into one of three actions: a self-timed byte write, a self-timed lock-bit write, or a chip erase that only takes effect if the pulse is held low long enough. Ready stays low while an operation runs, and any pulse that arrives during that time is discarded.

Reads are combinational from the current inputs. A verify read returns the stored byte, unless a read-protection lock bit is set. While a byte write is running, a verify of the address being written returns an inverted top bit, so the host can poll for completion. A signature read returns fixed identification bytes. Programming can only clear bits. The chip erase is the only way to return bytes to all ones and to clear the lock bits.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, ready is 1, no lock bit is set, and a verify read (op 0) of every address returns FFh.
- R2: When a program pulse is taken with op 1 while ready, ready goes low at the next clock edge and stays low for exactly WRITE_CYC cycles. At the edge where ready returns high, the stored byte becomes its old value AND the latched data. A program pulse is taken at a clock edge that samples prog_n low after an edge that sampled it high.
- R3: While a byte write runs, a verify of the written address returns bit 7 as the inverse of the written bit 7, with bits 6:0 taken from the still-unchanged stored byte. Verify of any other address returns its stored byte. After ready rises, the written address returns the new byte.
- R4: A byte that is already programmed can only lose ones when it is written again; no write can set a bit back to one. After a chip erase, any value can be written.
- R5: A program pulse that arrives while ready is low is ignored. The running operation keeps its timing, and the pulse's address and data are not written.
- R6: A chip erase starts on a pulse taken with op 3. If prog_n is sampled low at that edge and at each of the next ERASE_CYC edges, every byte becomes FFh and all lock bits clear at the last of those edges. Ready is low from the start edge until that edge. If prog_n is released earlier, the erase is cancelled and nothing changes.
- R7: A pulse with op 2 sets one lock bit, chosen by addr[1:0]: 1 selects lock bit 1, 2 selects lock bit 2, and 3 selects lock bit 3. The lock write is self-timed exactly like a byte write. With addr[1:0] equal to 0, no lock bit changes.
- R8: While lock bit 1 or lock bit 2 is set, a verify read returns 00h. Lock bit 3 on its own does not block verify.
- R9: A signature read (op 4) returns 1Eh at address 030h and 51h at address 031h. At address 032h it returns FFh when HV_VARIANT is 1 and 05h otherwise. It returns FFh at every other address. Lock bits do not affect signature reads. Op codes 5 to 7 read FFh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 3 | Operation: 0 verify, 1 program byte, 2 program lock bit, 3 chip erase, 4 signature |
| addr | input | ADDR_W | Byte address, or lock-bit index in addr[1:0] for op 2 |
| wdata | input | 8 | Byte to program |
| prog_n | input | 1 | Active-low program pulse |
| rdata | output | 8 | Read result for the current op and addr |
| ready | output | 1 | 1 when idle, 0 while a write or an erase hold runs |

## Verification
The read path is combinational, so the bench sets op and addr one time unit after a falling clock edge and samples rdata in that same half cycle. Ready drops on the first rising edge that samples the pulse. The bench counts the falling edges on which ready is low and expects WRITE_CYC for a write and ERASE_CYC for an erase. The poll value is sampled at the first falling edge after the pulse, while the write is certainly still running. The committed byte is read back only after ready has risen. In the test of an ignored pulse, the second pulse falls three cycles into the write, and the bench confirms that ready is still low on the eighth falling edge and high on the ninth.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

    typedef enum logic [2:0] {
        OP_VERIFY = 3'd0,
        OP_PROG   = 3'd1,
        OP_LOCK   = 3'd2,
        OP_ERASE  = 3'd3,
        OP_SIG    = 3'd4
    } fop_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_ERASE = 2'd2,
        ST_HOLD  = 2'd3
    } fst_e;

    localparam logic [7:0] BLANK_BYTE  = 8'hFF;
    localparam logic [7:0] HIDDEN_BYTE = 8'h00;

endpackage

// File: rtl/flash_array.sv
module flash_array #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              erase_all,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Writes only clear bits; erase restores every cell to ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
        end else if (erase_all) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
        end else if (wr_en) begin
            cells[wr_addr] <= cells[wr_addr] & wr_data;
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/flash_sig_rom.sv
module flash_sig_rom #(
    parameter int ADDR_W     = 12,
    parameter bit HV_VARIANT = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [7:0]        sig_byte
);
    localparam logic [ADDR_W-1:0] ID_MAKER  = ADDR_W'(48);
    localparam logic [ADDR_W-1:0] ID_FAMILY = ADDR_W'(49);
    localparam logic [ADDR_W-1:0] ID_VPROG  = ADDR_W'(50);
    localparam logic [7:0]        VPROG_VAL = HV_VARIANT ? 8'hFF : 8'h05;

    always_comb begin
        if (addr == ID_MAKER)       sig_byte = 8'h1E;
        else if (addr == ID_FAMILY) sig_byte = 8'h51;
        else if (addr == ID_VPROG)  sig_byte = VPROG_VAL;
        else                        sig_byte = 8'hFF;
    end

endmodule

// File: rtl/flash_read_mux.sv
module flash_read_mux
    import flash_prog_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] arr_byte,
    input  logic [7:0]        sig_byte,
    input  logic              lock_blk,
    input  logic              poll_hit,
    input  logic              poll_bit,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        case (op)
            OP_VERIFY: begin
                if (lock_blk)      rdata = HIDDEN_BYTE;
                else if (poll_hit) rdata = {poll_bit, arr_byte[DATA_W-2:0]};
                else               rdata = arr_byte;
            end
            OP_SIG:  rdata = sig_byte;
            default: rdata = BLANK_BYTE;
        endcase
    end

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
    import flash_prog_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 8,
    parameter int WRITE_CYC  = 1500,
    parameter int ERASE_CYC  = 10000,
    parameter bit HV_VARIANT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              prog_n,
    output logic [DATA_W-1:0] rdata,
    output logic              ready
);
    localparam int MAX_CYC = (ERASE_CYC > WRITE_CYC) ? ERASE_CYC : WRITE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WRITE_CYC - 1);
    localparam logic [CNT_W-1:0] ER_LOAD = CNT_W'(ERASE_CYC - 1);

    typedef struct packed {
        fst_e              st;
        logic [CNT_W-1:0]  cnt;
        logic              is_lock;
        logic [ADDR_W-1:0] wa;
        logic [DATA_W-1:0] wd;
        logic [2:0]        lock;
        logic              prog_prev;
    } ctl_t;

    ctl_t ctl_q, ctl_d;
    logic wr_en, erase_all, pulse;
    logic wr_busy, cnt_zero, lock_blk, poll_hit;
    logic [DATA_W-1:0] arr_byte;
    logic [7:0]        sig_byte;

    assign pulse    = ctl_q.prog_prev & ~prog_n;
    assign cnt_zero = (ctl_q.cnt == '0);
    assign wr_busy  = (ctl_q.st == ST_WRITE);
    assign lock_blk = ctl_q.lock[0] | ctl_q.lock[1];
    assign poll_hit = wr_busy & ~ctl_q.is_lock & (addr == ctl_q.wa);
    assign ready    = (ctl_q.st == ST_IDLE) | (ctl_q.st == ST_HOLD);

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.prog_prev = prog_n;
        wr_en           = 1'b0;
        erase_all       = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (pulse) begin
                    case (op)
                        OP_PROG, OP_LOCK: begin
                            ctl_d.st      = ST_WRITE;
                            ctl_d.cnt     = WR_LOAD;
                            ctl_d.is_lock = (op == OP_LOCK);
                            ctl_d.wa      = addr;
                            ctl_d.wd      = wdata;
                        end
                        OP_ERASE: begin
                            ctl_d.st  = ST_ERASE;
                            ctl_d.cnt = ER_LOAD;
                        end
                        default: ;
                    endcase
                end
            end
            ST_WRITE: begin
                if (cnt_zero) begin
                    ctl_d.st = ST_IDLE;
                    if (ctl_q.is_lock) begin
                        case (ctl_q.wa[1:0])
                            2'd1:    ctl_d.lock[0] = 1'b1;
                            2'd2:    ctl_d.lock[1] = 1'b1;
                            2'd3:    ctl_d.lock[2] = 1'b1;
                            default: ;
                        endcase
                    end else begin
                        wr_en = 1'b1;
                    end
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_ERASE: begin
                if (prog_n) begin
                    ctl_d.st = ST_IDLE;          // released too early: cancel
                end else if (cnt_zero) begin
                    erase_all  = 1'b1;
                    ctl_d.lock = '0;
                    ctl_d.st   = ST_HOLD;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_HOLD: begin
                if (prog_n) ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st        <= ST_IDLE;
            ctl_q.cnt       <= '0;
            ctl_q.is_lock   <= 1'b0;
            ctl_q.wa        <= '0;
            ctl_q.wd        <= '0;
            ctl_q.lock      <= '0;
            ctl_q.prog_prev <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    flash_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (ctl_q.wa),
        .wr_data   (ctl_q.wd),
        .erase_all (erase_all),
        .rd_addr   (addr),
        .rd_data   (arr_byte)
    );

    flash_sig_rom #(.ADDR_W(ADDR_W), .HV_VARIANT(HV_VARIANT)) u_sig (
        .addr     (addr),
        .sig_byte (sig_byte)
    );

    flash_read_mux #(.DATA_W(DATA_W)) u_rmux (
        .op       (op),
        .arr_byte (arr_byte),
        .sig_byte (sig_byte),
        .lock_blk (lock_blk),
        .poll_hit (poll_hit),
        .poll_bit (~ctl_q.wd[DATA_W-1]),
        .rdata    (rdata)
    );

endmodule

// File: rtl/flash_prog_seq_chk.sv
module flash_prog_seq_chk
    import flash_prog_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        op,
    input logic [ADDR_W-1:0] addr,
    input logic              prog_n,
    input logic              ready,
    input logic [DATA_W-1:0] rdata,
    input logic              wr_busy,
    input logic              cnt_zero,
    input logic              lock_blk
);
    // R2: ready only drops after a low sample of the program pulse
    a_r2_drop_needs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> !$past(prog_n));

    // R2 / R6: ready returns only at the end of a count or on an early release
    a_r2_rise_at_count: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(cnt_zero) || $past(prog_n)));

    // R5: an unfinished write keeps ready low regardless of new pulses
    a_r5_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_busy && !cnt_zero) |=> !ready);

    // R8: a set read-protection bit hides verify data
    a_r8_lock_hides: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_blk && op == OP_VERIFY) |-> (rdata == '0));

    // R9: the maker identification byte is fixed
    a_r9_sig_maker: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SIG && addr == ADDR_W'(48)) |-> (rdata == 8'h1E));

endmodule

bind flash_prog_seq flash_prog_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .addr     (addr),
    .prog_n   (prog_n),
    .ready    (ready),
    .rdata    (rdata),
    .wr_busy  (wr_busy),
    .cnt_zero (cnt_zero),
    .lock_blk (lock_blk)
);

// File: tb/flash_prog_seq_bench.sv
module flash_prog_seq_bench;
    localparam int AW = 12;
    localparam int DEPTH = 1 << AW;
    localparam int WC = 8;
    localparam int EC = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    op = 3'd0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic          prog_n = 1'b1;
    logic [7:0]    rdata;
    logic          ready;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [7:0] model [DEPTH];

    always #5 clk = ~clk;

    flash_prog_seq #(.ADDR_W(AW), .DATA_W(8), .WRITE_CYC(WC), .ERASE_CYC(EC),
                     .HV_VARIANT(1'b1)) u_flash_prog_seq (
        .clk(clk), .rst_n(rst_n), .op(op), .addr(addr), .wdata(wdata),
        .prog_n(prog_n), .rdata(rdata), .ready(ready));

    function automatic logic [7:0] pat1(int a);
        return 8'((a * 73) + (a >> 4) + 9);
    endfunction

    function automatic logic [7:0] pat2(int a);
        return 8'((a * 29) ^ 8'hA5) | 8'h11;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic read_at(input logic [2:0] o, input int a, output logic [7:0] v);
        @(negedge clk);
        op = o; addr = AW'(a);
        #1 v = rdata;
    endtask

    // Pulse once, then poll this address and its neighbour, then count busy cycles.
    task automatic pulse_op(input logic [2:0] o, input int a, input logic [7:0] dv,
                            output int busy, output logic [7:0] poll, output logic [7:0] side);
        @(negedge clk);
        op = o; addr = AW'(a); wdata = dv; prog_n = 1'b0;
        @(negedge clk);
        prog_n = 1'b1; op = 3'd0;
        #1 poll = rdata;
        addr = AW'(a) ^ AW'(1);
        #1 side = rdata;
        addr = AW'(a);
        busy = 0;
        while (!ready && busy < 200) begin
            busy++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all requirements: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int b;
        logic [7:0] v, pl, sd;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        check("R1 ready in reset", int'(ready), 1);
        rst_n = 1'b1;

        // R1: blank array after reset
        for (int a = 0; a < DEPTH; a++) begin
            read_at(3'd0, a, v);
            check("R1 blank read", v, 8'hFF);
        end
        check("R1 ready after reset", int'(ready), 1);

        // R9: signature bytes
        read_at(3'd4, 48, v); check("R9 sig 030", v, 8'h1E);
        read_at(3'd4, 49, v); check("R9 sig 031", v, 8'h51);
        read_at(3'd4, 50, v); check("R9 sig 032", v, 8'hFF);
        read_at(3'd4, 51, v); check("R9 sig other", v, 8'hFF);
        read_at(3'd6, 48, v); check("R9 unused op", v, 8'hFF);

        // R2 / R3: timed write with completion poll
        pulse_op(3'd1, 12'h123, 8'hDA, b, pl, sd);
        check("R2 busy cycles", b, WC);
        check("R3 poll value", pl, 8'h7F);
        check("R3 neighbour during write", sd, 8'hFF);
        read_at(3'd0, 12'h123, v); check("R2 committed byte", v, 8'hDA);
        model[12'h123] = 8'hDA;

        // R5: pulse during busy ignored
        @(negedge clk);
        op = 3'd1; addr = 12'h200; wdata = 8'h00; prog_n = 1'b0;
        @(negedge clk); prog_n = 1'b1;
        @(negedge clk);
        @(negedge clk); addr = 12'h201; prog_n = 1'b0;
        @(negedge clk); prog_n = 1'b1; op = 3'd0;
        repeat (4) @(negedge clk);
        #1 check("R5 still busy at cycle 8", int'(ready), 0);
        @(negedge clk);
        #1 check("R5 ready at cycle 9", int'(ready), 1);
        read_at(3'd0, 12'h201, v); check("R5 ignored address untouched", v, 8'hFF);
        read_at(3'd0, 12'h200, v); check("R5 first write done", v, 8'h00);
        model[12'h200] = 8'h00;

        // R2 / R4: full sweep, then AND-overwrite of the first 256 bytes
        for (int a = 0; a < DEPTH; a++) begin
            pulse_op(3'd1, a, pat1(a), b, pl, sd);
            model[a] = model[a] & pat1(a);
        end
        for (int a = 0; a < DEPTH; a++) begin
            read_at(3'd0, a, v);
            check("R2 sweep readback", v, model[a]);
        end
        for (int a = 0; a < 256; a++) begin
            pulse_op(3'd1, a, pat2(a), b, pl, sd);
            check("R4 rewrite timing", b, WC);
            model[a] = model[a] & pat2(a);
            read_at(3'd0, a, v);
            check("R4 bits only clear", v, model[a]);
        end

        // R7 / R8: lock bit 3 alone does not hide, lock bit 1 does
        pulse_op(3'd2, 0, 8'h00, b, pl, sd);
        check("R7 index 0 timing", b, WC);
        read_at(3'd0, 7, v); check("R7 index 0 sets nothing", v, model[7]);
        pulse_op(3'd2, 3, 8'h00, b, pl, sd);
        check("R7 lock write timing", b, WC);
        read_at(3'd0, 7, v); check("R8 lock3 keeps verify", v, model[7]);
        pulse_op(3'd2, 1, 8'h00, b, pl, sd);
        read_at(3'd0, 7, v); check("R8 lock1 hides verify", v, 8'h00);
        read_at(3'd4, 49, v); check("R9 sig with lock", v, 8'h51);

        // R6: early release cancels erase
        @(negedge clk);
        op = 3'd3; prog_n = 1'b0;
        repeat (5) @(negedge clk);
        #1 check("R6 busy during hold", int'(ready), 0);
        prog_n = 1'b1;
        @(negedge clk);
        #1 check("R6 ready after cancel", int'(ready), 1);
        read_at(3'd0, 7, v); check("R6 cancel keeps lock", v, 8'h00);

        // R6: full erase
        @(negedge clk);
        op = 3'd3; prog_n = 1'b0;
        @(negedge clk);
        b = 0;
        while (!ready && b < 200) begin
            b++;
            @(negedge clk);
        end
        check("R6 erase hold cycles", b, EC);
        prog_n = 1'b1;
        for (int a = 0; a < DEPTH; a++) begin
            read_at(3'd0, a, v);
            check("R6 erased and unlocked", v, 8'hFF);
            model[a] = 8'hFF;
        end

        // R4: after erase a fresh value can be written
        pulse_op(3'd1, 5, 8'h33, b, pl, sd);
        read_at(3'd0, 5, v); check("R4 write after erase", v, 8'h33);
        pulse_op(3'd1, 5, 8'hF0, b, pl, sd);
        read_at(3'd0, 5, v); check("R4 no bit set back", v, 8'h30);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule